// File: doc/BRIEF.md
# Second Operand Source Decoder

This block is the part of an instruction decode stage that works out where the second source operand of a 32-bit fixed-width instruction comes from. It takes the raw instruction word and a 4-bit source selector from the primary decoder. From these it produces three requests. The first is a general-register read, given as a valid flag and a 5-bit index. The second is a special-purpose-register read, given as a valid flag and a 10-bit id. The third is a 64-bit immediate, given as a valid flag and a value. At most one of the three is raised for any selector.

The block is purely combinational. It has no clock, no reset and no states, so the state-machine layout of the house style is reduced to a single named decode process in the top module. Field extraction sits in one submodule and immediate formatting in another. The top module picks between the register path, the link/count SPR path and the immediate path.

Instruction bit numbering in this document is LSB = bit 0. Selector codes are: 0 none, 1 register, 2 SPR, 3 UI, 4 SI, 5 UI_HI, 6 SI_HI, 7 LI, 8 BD, 9 DS, 10 M1, 11 SH, 12 SH32. Codes 13 to 15 are unused.

Top module: `opb_src_decode`

## Requirements
- R1: Selector 1 raises the register-read flag with index = instruction bits 15:11; the SPR and immediate flags are 0.
- R2: Selector 0 drives every flag and every data output to 0.
- R3: Selector 2 raises the SPR-read flag only. The id is 9 (count register) when instruction bit 10 is 1, and 8 (link register) when it is 0.
- R4: Selector 3 gives bits 15:0 zero-extended. Selector 4 gives bits 15:0 sign-extended to 64 bits.
- R5: Selector 5 places bits 15:0 in immediate bits 31:16, with zeros below and above. Selector 6 does the same but sign-extends above bit 31.
- R6: Selector 7 gives {bits 25:2, 2'b00} sign-extended from bit 25. Selectors 8 and 9 each give {bits 15:2, 2'b00} sign-extended from bit 15.
- R7: Selector 10 gives an immediate of all ones.
- R8: Selector 11 gives the 6-bit value {bit 1, bits 15:11} zero-extended. Selector 12 gives bits 15:11 zero-extended.
- R9: Selectors 3 to 12 raise the immediate flag and clear the register and SPR flags.
- R10: Every output whose valid flag is 0 reads 0. Selectors 13 to 15 produce all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| inst_word | input | 32 | Raw instruction word |
| opb_sel | input | 4 | Operand B source selector code |
| reg_rd_vld | output | 1 | General register read requested |
| reg_rd_idx | output | 5 | General register index |
| spr_rd_vld | output | 1 | Special register read requested |
| spr_rd_id | output | 10 | Special register id (8 link, 9 count) |
| imm_vld | output | 1 | Immediate operand valid |
| imm_val | output | 64 | Formatted immediate value |

## Verification
The assertions assume that both inputs are settled two-state values when they are evaluated. They place no limit on the selector range, because codes 13 to 15 have a defined all-zero result.

The bench changes inputs only on the falling clock edge and samples one time unit later, so each comparison sees a settled decode. Instruction words come from a deterministic generator and from hand-picked patterns that flip the sign bits, bit 10 and bit 1. Every selector code is covered, including the unused ones.

// File: rtl/opb_pkg.sv
package opb_pkg;
    localparam int SEL_W    = 4;
    localparam int SPR_ID_W = 10;

    typedef enum logic [SEL_W-1:0] {
        SEL_NONE  = 4'd0,
        SEL_RB    = 4'd1,
        SEL_SPR   = 4'd2,
        SEL_UI    = 4'd3,
        SEL_SI    = 4'd4,
        SEL_UI_HI = 4'd5,
        SEL_SI_HI = 4'd6,
        SEL_LI    = 4'd7,
        SEL_BD    = 4'd8,
        SEL_DS    = 4'd9,
        SEL_M1    = 4'd10,
        SEL_SH    = 4'd11,
        SEL_SH32  = 4'd12
    } opb_sel_e;

    localparam logic [SPR_ID_W-1:0] SPR_LINK  = 10'd8;
    localparam logic [SPR_ID_W-1:0] SPR_COUNT = 10'd9;
endpackage

// File: rtl/opb_fields.sv
module opb_fields #(
    parameter int INST_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic [INST_W-1:0] inst_i,
    output logic [IDX_W-1:0]  rb_o,
    output logic [15:0]       half_o,
    output logic [23:0]       long_disp_o,
    output logic [13:0]       short_disp_o,
    output logic [5:0]        sh6_o,
    output logic [4:0]        sh5_o,
    output logic              xo_top_o
);
    logic unused_opcode;

    always_comb begin
        rb_o         = inst_i[15:11];
        half_o       = inst_i[15:0];
        long_disp_o  = inst_i[25:2];
        short_disp_o = inst_i[15:2];
        sh6_o        = {inst_i[1], inst_i[15:11]};
        sh5_o        = inst_i[15:11];
        xo_top_o     = inst_i[10];
    end

    assign unused_opcode = ^inst_i[INST_W-1:26];
endmodule

// File: rtl/opb_imm_gen.sv
module opb_imm_gen
    import opb_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  opb_sel_e        sel_i,
    input  logic [15:0]     half_i,
    input  logic [23:0]     long_disp_i,
    input  logic [13:0]     short_disp_i,
    input  logic [5:0]      sh6_i,
    input  logic [4:0]      sh5_i,
    output logic            hit_o,
    output logic [XLEN-1:0] imm_o
);
    always_comb begin
        imm_o = '0;
        hit_o = 1'b1;
        case (sel_i)
            SEL_UI:    imm_o = XLEN'(half_i);
            SEL_SI:    imm_o = XLEN'($signed(half_i));
            SEL_UI_HI: imm_o = XLEN'({half_i, 16'h0000});
            SEL_SI_HI: imm_o = XLEN'($signed({half_i, 16'h0000}));
            SEL_LI:    imm_o = XLEN'($signed({long_disp_i, 2'b00}));
            SEL_BD,
            SEL_DS:    imm_o = XLEN'($signed({short_disp_i, 2'b00}));
            SEL_M1:    imm_o = '1;
            SEL_SH:    imm_o = XLEN'(sh6_i);
            SEL_SH32:  imm_o = XLEN'(sh5_i);
            default:   hit_o = 1'b0;
        endcase
    end

    always_comb begin
        // R7
        m1_ones_chk: assert (sel_i != SEL_M1 || &imm_o)
            else $error("M1 immediate not all ones");
        // R4
        si_ext_chk: assert (sel_i != SEL_SI || &imm_o[XLEN-1:15] || ~|imm_o[XLEN-1:15])
            else $error("SI immediate upper bits not a sign copy");
        // R6
        disp_align_chk: assert (!(sel_i inside {SEL_LI, SEL_BD, SEL_DS}) || imm_o[1:0] == 2'b00)
            else $error("displacement not word aligned");
        // R5
        hi_low_zero_chk: assert (!(sel_i inside {SEL_UI_HI, SEL_SI_HI}) || imm_o[15:0] == 16'h0)
            else $error("high immediate low half not zero");
    end
endmodule

// File: rtl/opb_src_decode.sv
module opb_src_decode
    import opb_pkg::*;
#(
    parameter int INST_W = 32,
    parameter int IDX_W  = 5,
    parameter int XLEN   = 64
) (
    input  logic [INST_W-1:0]   inst_word,
    input  logic [SEL_W-1:0]    opb_sel,
    output logic                reg_rd_vld,
    output logic [IDX_W-1:0]    reg_rd_idx,
    output logic                spr_rd_vld,
    output logic [SPR_ID_W-1:0] spr_rd_id,
    output logic                imm_vld,
    output logic [XLEN-1:0]     imm_val
);
    opb_sel_e    sel;
    logic [IDX_W-1:0] rb_f;
    logic [15:0] half_f;
    logic [23:0] long_f;
    logic [13:0] short_f;
    logic [5:0]  sh6_f;
    logic [4:0]  sh5_f;
    logic        xo_top_f;
    logic        imm_hit;
    logic [XLEN-1:0] imm_raw;

    assign sel = opb_sel_e'(opb_sel);

    opb_fields #(.INST_W(INST_W), .IDX_W(IDX_W)) u_fields (
        .inst_i       (inst_word),
        .rb_o         (rb_f),
        .half_o       (half_f),
        .long_disp_o  (long_f),
        .short_disp_o (short_f),
        .sh6_o        (sh6_f),
        .sh5_o        (sh5_f),
        .xo_top_o     (xo_top_f)
    );

    opb_imm_gen #(.XLEN(XLEN)) u_imm (
        .sel_i        (sel),
        .half_i       (half_f),
        .long_disp_i  (long_f),
        .short_disp_i (short_f),
        .sh6_i        (sh6_f),
        .sh5_i        (sh5_f),
        .hit_o        (imm_hit),
        .imm_o        (imm_raw)
    );

    always_comb begin
        reg_rd_vld = 1'b0;
        reg_rd_idx = '0;
        spr_rd_vld = 1'b0;
        spr_rd_id  = '0;
        imm_vld    = 1'b0;
        imm_val    = '0;
        case (sel)
            SEL_RB: begin
                reg_rd_vld = 1'b1;
                reg_rd_idx = rb_f;
            end
            SEL_SPR: begin
                spr_rd_vld = 1'b1;
                spr_rd_id  = xo_top_f ? SPR_COUNT : SPR_LINK;
            end
            default: begin
                imm_vld = imm_hit;
                imm_val = imm_hit ? imm_raw : '0;
            end
        endcase
    end

    always_comb begin
        // R9
        one_source_chk: assert ($onehot0({reg_rd_vld, spr_rd_vld, imm_vld}))
            else $error("more than one operand source raised");
        // R3
        spr_pick_chk: assert (!spr_rd_vld || spr_rd_id == SPR_LINK || spr_rd_id == SPR_COUNT)
            else $error("SPR id outside link/count");
        // R10
        idle_imm_zero_chk: assert (imm_vld || imm_val == '0)
            else $error("immediate nonzero while not valid");
        // R1
        reg_field_chk: assert (!reg_rd_vld || reg_rd_idx == inst_word[15:11])
            else $error("register index does not match field");
        // R2
        none_quiet_chk: assert (opb_sel != SEL_W'(0) || !(reg_rd_vld || spr_rd_vld || imm_vld))
            else $error("selector none raised a request");
    end
endmodule

// File: tb/opb_src_decode_bench.sv
module opb_src_decode_bench;
    logic        clk = 1'b0;
    logic [31:0] inst_word = '0;
    logic [3:0]  opb_sel = '0;
    logic        reg_rd_vld, spr_rd_vld, imm_vld;
    logic [4:0]  reg_rd_idx;
    logic [9:0]  spr_rd_id;
    logic [63:0] imm_val;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [31:0] lcg = 32'h1234_5678;

    always #2 clk = ~clk;

    opb_src_decode u_opb_src_decode (
        .inst_word  (inst_word),
        .opb_sel    (opb_sel),
        .reg_rd_vld (reg_rd_vld),
        .reg_rd_idx (reg_rd_idx),
        .spr_rd_vld (spr_rd_vld),
        .spr_rd_id  (spr_rd_id),
        .imm_vld    (imm_vld),
        .imm_val    (imm_val)
    );

    function automatic logic [31:0] next_rand();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg ^ {lcg[15:0], lcg[31:16]};
    endfunction

    function automatic string req_of(logic [3:0] s);
        case (s)
            4'd0: return "R2";
            4'd1: return "R1";
            4'd2: return "R3";
            4'd3, 4'd4: return "R4";
            4'd5, 4'd6: return "R5";
            4'd7, 4'd8, 4'd9: return "R6";
            4'd10: return "R7";
            4'd11, 4'd12: return "R8";
            default: return "R10";
        endcase
    endfunction

    // Expected outputs packed as {rv, idx, sv, id, iv, imm}
    function automatic logic [81:0] model(logic [3:0] s, logic [31:0] w);
        logic rv, sv, iv;
        logic [4:0] idx;
        logic [9:0] id;
        logic [63:0] imm;
        rv = 0; sv = 0; iv = 1; idx = 0; id = 0; imm = 0;
        case (s)
            4'd0: iv = 0;
            4'd1: begin iv = 0; rv = 1; idx = w[15:11]; end
            4'd2: begin iv = 0; sv = 1; id = w[10] ? 10'd9 : 10'd8; end
            4'd3: imm = {48'd0, w[15:0]};
            4'd4: imm = {{48{w[15]}}, w[15:0]};
            4'd5: imm = {32'd0, w[15:0], 16'd0};
            4'd6: imm = {{32{w[15]}}, w[15:0], 16'd0};
            4'd7: imm = {{38{w[25]}}, w[25:2], 2'b00};
            4'd8, 4'd9: imm = {{48{w[15]}}, w[15:2], 2'b00};
            4'd10: imm = {64{1'b1}};
            4'd11: imm = {58'd0, w[1], w[15:11]};
            4'd12: imm = {59'd0, w[15:11]};
            default: iv = 0;
        endcase
        return {rv, idx, sv, id, iv, imm};
    endfunction

    task automatic apply(input logic [3:0] s, input logic [31:0] w, input string tag);
        logic [81:0] exp_v, act_v;
        @(negedge clk);
        opb_sel = s;
        inst_word = w;
        #1;
        exp_v = model(s, w);
        act_v = {reg_rd_vld, reg_rd_idx, spr_rd_vld, spr_rd_id, imm_vld, imm_val};
        total++;
        if (act_v !== exp_v) begin
            bad++;
            $display("FAIL %s sel=%0d inst=%h actual=%h expected=%h", tag, s, w, act_v, exp_v);
        end
    endtask

    task automatic t_reset_state();
        apply(4'd0, 32'h0, "R2");
        apply(4'd0, 32'hFFFF_FFFF, "R2");
    endtask

    task automatic t_register();
        apply(4'd1, 32'h0000_F800, "R1");
        apply(4'd1, 32'hFFFF_07FF, "R1");
        apply(4'd1, 32'h0000_5800, "R1");
    endtask

    task automatic t_spr();
        apply(4'd2, 32'h0000_0420, "R3");
        apply(4'd2, 32'hFFFF_FBFF, "R3");
        apply(4'd2, 32'h0000_0400, "R3");
    endtask

    task automatic t_half();
        apply(4'd3, 32'h0000_8001, "R4");
        apply(4'd4, 32'h0000_8001, "R4");
        apply(4'd4, 32'h0000_7FFF, "R4");
        apply(4'd5, 32'h0000_8001, "R5");
        apply(4'd6, 32'h0000_8001, "R5");
        apply(4'd6, 32'h0000_1234, "R5");
    endtask

    task automatic t_disp();
        apply(4'd7, 32'h0200_0000, "R6");
        apply(4'd7, 32'h01FF_FFFC, "R6");
        apply(4'd8, 32'h0000_8004, "R6");
        apply(4'd9, 32'h0000_7FFF, "R6");
    endtask

    task automatic t_misc();
        apply(4'd10, 32'h0, "R7");
        apply(4'd11, 32'h0000_F802, "R8");
        apply(4'd11, 32'h0000_0002, "R8");
        apply(4'd12, 32'h0000_F803, "R8");
        apply(4'd13, 32'hFFFF_FFFF, "R10");
        apply(4'd15, 32'hFFFF_FFFF, "R10");
    endtask

    task automatic t_sweep();
        for (int s = 0; s < 16; s++) begin
            for (int k = 0; k < 150; k++) begin
                apply(4'(s), next_rand(), (s >= 3 && s <= 12) ? {req_of(4'(s)), "/R9"} : req_of(4'(s)));
            end
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        t_reset_state();
        t_register();
        t_spr();
        t_half();
        t_disp();
        t_misc();
        t_sweep();
        finish_run();
    end
endmodule